// File: doc/BRIEF.md
# SECDED Hamming ECC Codec for One Byte

This block protects one 8-bit byte with a 13-bit codeword that can correct any single flipped bit and detect any two flipped bits. The encoder places the byte in the non-power-of-two slots of a 12-position Hamming word. It fills the four power-of-two slots with check bits and appends an overall parity bit as position 13.

The decoder accepts a word that may be corrupted. It returns the repaired byte, the 4-bit syndrome and exactly one of three outcome flags:

- clean: nothing was wrong.
- fixed: one bit was wrong and has been repaired.
- fatal: the damage is beyond repair.

Each path is a single register stage gated by its own valid input. A surrounding memory controller encodes on the way in and decodes on the way out.

Codeword bit `p-1` carries position `p`, for positions 1 to 13.

Top module: `secded_codec`

## Requirements
- R1: The encoder places data bits 7 down to 0 at positions 3, 5, 6, 7, 9, 10, 11 and 12, in that order. The check bit at position 2^k is the XOR of every data position whose index has bit k set. For example, byte 0xC4 encodes to 13'h129C.
- R2: Encoder output bit 12 (position 13) makes the XOR of all 13 codeword bits equal zero.
- R3: Each output valid equals its input valid one clock earlier, and each path's outputs are registered.
- R4: A synchronous active-high reset clears both output valids and all three decoder flags at the next clock edge.
- R5: The decoder syndrome output has C1 in bit 0 up to C8 in bit 3. Ck is the XOR of all received positions 1 to 12 whose index has bit k set.
- R6: A zero syndrome with even overall parity raises only the clean flag, and the data from positions 3 to 12 is returned unchanged.
- R7: A nonzero syndrome of 1 to 12 with odd parity raises only the fixed flag. The indicated position is inverted before the data is extracted, so an error in a check position leaves the data as received.
- R8: A zero syndrome with odd parity (position 13 alone flipped) raises only the fixed flag and returns the data unchanged.
- R9: A nonzero syndrome with even parity raises only the fatal flag and returns the uncorrected data.
- R10: A syndrome of 13, 14 or 15 with odd parity raises only the fatal flag, and no bit is inverted.
- R11: While the decoder output valid is high, exactly one flag is set. While it is low, all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_valid_i | input | 1 | Encoder input valid |
| enc_data_i | input | 8 | Byte to encode |
| enc_valid_o | output | 1 | Encoder output valid |
| enc_word_o | output | 13 | Codeword, position p at bit p-1 |
| dec_valid_i | input | 1 | Decoder input valid |
| dec_word_i | input | 13 | Received codeword |
| dec_valid_o | output | 1 | Decoder output valid |
| dec_data_o | output | 8 | Corrected byte |
| dec_syndrome_o | output | 4 | Syndrome C8..C1 |
| dec_clean_o | output | 1 | No error found |
| dec_fixed_o | output | 1 | Single error repaired |
| dec_fatal_o | output | 1 | Uncorrectable error |

## Verification
The encoder is tried with all 256 bytes, which checks the data placement and every check equation against an independent table of explicit XORs.

The decoder is tried with several bytes under four kinds of damage:

- No flip, which separates clean from the other outcomes.
- Each single flip over all 13 positions, which separates data, check and parity positions.
- Every pair of flips, which must all be fatal.
- Three hand-picked triple flips whose syndromes are 13, 14 and 15, which separate out-of-range syndromes from repairable ones.

Reset during traffic and idle cycles show that valids and flags drop.

// File: rtl/secded_pkg.sv
package secded_pkg;

  localparam int DATA_W = 8;

  function automatic int chk_count(int dw);
    int r;
    r = 0;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction

  localparam int CHK_W = chk_count(DATA_W);
  localparam int HAM_N = DATA_W + CHK_W;
  localparam int CW_W  = HAM_N + 1;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [CW_W-1:0]   word_t;
  typedef logic [CHK_W-1:0]  syn_t;

  function automatic bit is_pow2(int p);
    return (p & (p - 1)) == 0;
  endfunction

  // XOR of all positions 1..HAM_N whose index has bit k set
  function automatic logic group_parity(word_t w, int k);
    logic c;
    c = 1'b0;
    for (int p = 1; p <= HAM_N; p++)
      if (((p >> k) & 1) == 1) c = c ^ w[p-1];
    return c;
  endfunction

  function automatic word_t place_data(data_t d);
    word_t w;
    int idx;
    w = '0;
    idx = DATA_W - 1;
    for (int p = 1; p <= HAM_N; p++)
      if (!is_pow2(p)) begin
        w[p-1] = d[idx];
        idx--;
      end
    return w;
  endfunction

  function automatic data_t extract_data(word_t w);
    data_t d;
    int idx;
    d = '0;
    idx = DATA_W - 1;
    for (int p = 1; p <= HAM_N; p++)
      if (!is_pow2(p)) begin
        d[idx] = w[p-1];
        idx--;
      end
    return d;
  endfunction

  function automatic word_t encode_word(data_t d);
    word_t w;
    w = place_data(d);
    for (int k = 0; k < CHK_W; k++)
      w[(1 << k) - 1] = group_parity(w, k);
    w[CW_W-1] = ^w[HAM_N-1:0];
    return w;
  endfunction

  function automatic syn_t syndrome_of(word_t w);
    syn_t s;
    for (int k = 0; k < CHK_W; k++)
      s[k] = group_parity(w, k);
    return s;
  endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  vin,
  input  data_t din,
  output logic  vout,
  output word_t wout
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vout <= 1'b0;
      wout <= '0;
    end else begin
      vout <= vin;
      if (vin) wout <= encode_word(din);
    end
  end

endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  vin,
  input  word_t win,
  output logic  vout,
  output data_t dout,
  output syn_t  sout,
  output logic  clean,
  output logic  fixed,
  output logic  fatal,
  output word_t flip
);

  syn_t syn_w;
  logic par_w, nz_w, beyond_w, single_w, pbit_w, double_w;

  always_comb begin
    syn_w    = syndrome_of(win);
    par_w    = ^win;
    nz_w     = |syn_w;
    beyond_w = int'(syn_w) > HAM_N;
    single_w = par_w & nz_w & !beyond_w;
    pbit_w   = par_w & !nz_w;
    double_w = !par_w & nz_w;
    flip     = single_w ? (word_t'(1) << (syn_w - syn_t'(1))) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vout  <= 1'b0;
      clean <= 1'b0;
      fixed <= 1'b0;
      fatal <= 1'b0;
      dout  <= '0;
      sout  <= '0;
    end else begin
      vout  <= vin;
      clean <= vin & !par_w & !nz_w;
      fixed <= vin & (single_w | pbit_w);
      fatal <= vin & (double_w | (par_w & beyond_w));
      if (vin) begin
        dout <= extract_data(win ^ flip);
        sout <= syn_w;
      end
    end
  end

endmodule

// File: rtl/secded_codec.sv
module secded_codec
  import secded_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              enc_valid_i,
  input  logic [DATA_W-1:0] enc_data_i,
  output logic              enc_valid_o,
  output logic [CW_W-1:0]   enc_word_o,
  input  logic              dec_valid_i,
  input  logic [CW_W-1:0]   dec_word_i,
  output logic              dec_valid_o,
  output logic [DATA_W-1:0] dec_data_o,
  output logic [CHK_W-1:0]  dec_syndrome_o,
  output logic              dec_clean_o,
  output logic              dec_fixed_o,
  output logic              dec_fatal_o
);

  // bit the decoder inverts this cycle (zero when nothing is repaired)
  word_t dec_flip_w;

  secded_enc u_enc (
    .clk  (clk),
    .rst  (rst),
    .vin  (enc_valid_i),
    .din  (enc_data_i),
    .vout (enc_valid_o),
    .wout (enc_word_o)
  );

  secded_dec u_dec (
    .clk   (clk),
    .rst   (rst),
    .vin   (dec_valid_i),
    .win   (dec_word_i),
    .vout  (dec_valid_o),
    .dout  (dec_data_o),
    .sout  (dec_syndrome_o),
    .clean (dec_clean_o),
    .fixed (dec_fixed_o),
    .fatal (dec_fatal_o),
    .flip  (dec_flip_w)
  );

endmodule

// File: rtl/secded_chk.sv
module secded_chk
  import secded_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       enc_valid_i,
  input logic       enc_valid_o,
  input word_t      enc_word_o,
  input logic       dec_valid_i,
  input word_t      dec_word_i,
  input logic       dec_valid_o,
  input syn_t       dec_syndrome_o,
  input logic       dec_clean_o,
  input logic       dec_fixed_o,
  input logic       dec_fatal_o,
  input word_t      dec_flip_w
);

  // R3
  enc_latency_chk: assert property (@(posedge clk) disable iff (rst)
    enc_valid_i |=> enc_valid_o);

  // R3
  enc_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !enc_valid_i |=> !enc_valid_o);

  // R3
  dec_latency_chk: assert property (@(posedge clk) disable iff (rst)
    dec_valid_i |=> dec_valid_o);

  // R3
  dec_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !dec_valid_i |=> !dec_valid_o);

  // R1
  enc_zero_syn_chk: assert property (@(posedge clk) disable iff (rst)
    enc_valid_o |-> (syndrome_of(enc_word_o) == '0));

  // R2
  enc_even_chk: assert property (@(posedge clk) disable iff (rst)
    enc_valid_o |-> (^enc_word_o == 1'b0));

  // R11
  flag_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    dec_valid_o |-> ($countones({dec_clean_o, dec_fixed_o, dec_fatal_o}) == 1));

  // R11
  flag_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !dec_valid_o |-> !(dec_clean_o | dec_fixed_o | dec_fatal_o));

  // R6
  clean_syn_chk: assert property (@(posedge clk) disable iff (rst)
    dec_clean_o |-> (dec_syndrome_o == '0));

  // R9
  fatal_syn_chk: assert property (@(posedge clk) disable iff (rst)
    dec_fatal_o |-> (dec_syndrome_o != '0));

  // R7
  single_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_valid_i && (dec_flip_w != '0)) |->
      ($countones(dec_flip_w) == 1 && !dec_flip_w[CW_W-1]));

  // R10
  beyond_noflip_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_valid_i && (int'(syndrome_of(dec_word_i)) > HAM_N)) |-> (dec_flip_w == '0));

endmodule

bind secded_codec secded_chk u_chk (.*);

// File: tb/sim_secded_codec.sv
`timescale 1ns/1ps
module sim_secded_codec;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enc_valid_i = 1'b0;
  logic [7:0]  enc_data_i = '0;
  logic        enc_valid_o;
  logic [12:0] enc_word_o;
  logic        dec_valid_i = 1'b0;
  logic [12:0] dec_word_i = '0;
  logic        dec_valid_o;
  logic [7:0]  dec_data_o;
  logic [3:0]  dec_syndrome_o;
  logic        dec_clean_o, dec_fixed_o, dec_fatal_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  secded_codec u0 (.*);

  // expected decoder item: data, syndrome, {clean,fixed,fatal}
  typedef struct packed {
    logic [7:0] data;
    logic [3:0] syn;
    logic [2:0] flags;
  } dec_exp_t;

  logic [12:0] enc_q[$];
  string       enc_tag_q[$];
  dec_exp_t    dec_q[$];
  string       dec_tag_q[$];

  // explicit-equation model of the codeword (R1, R2)
  function automatic logic [12:0] model_enc(logic [7:0] d);
    logic [13:1] h;
    h = '0;
    h[3] = d[7]; h[5] = d[6]; h[6] = d[5]; h[7] = d[4];
    h[9] = d[3]; h[10] = d[2]; h[11] = d[1]; h[12] = d[0];
    h[1] = h[3] ^ h[5] ^ h[7] ^ h[9] ^ h[11];
    h[2] = h[3] ^ h[6] ^ h[7] ^ h[10] ^ h[11];
    h[4] = h[5] ^ h[6] ^ h[7] ^ h[12];
    h[8] = h[9] ^ h[10] ^ h[11] ^ h[12];
    h[13] = ^h[12:1];
    return h;
  endfunction

  function automatic logic [7:0] model_data(logic [12:0] w);
    return {w[2], w[4], w[5], w[6], w[8], w[9], w[10], w[11]};
  endfunction

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic drive_enc(input logic [7:0] d, input logic [12:0] exp, input string tag);
    @(negedge clk);
    enc_valid_i = 1'b1;
    enc_data_i  = d;
    enc_q.push_back(exp);
    enc_tag_q.push_back(tag);
  endtask

  // mask holds flipped positions (bit p-1 = position p); expected outcome from flip count
  task automatic drive_dec(input logic [7:0] d, input logic [12:0] mask);
    logic [12:0] rx;
    logic [3:0]  s;
    dec_exp_t    e;
    string       tag;
    int          n;
    rx = model_enc(d) ^ mask;
    n = $countones(mask);
    s = '0;
    for (int p = 1; p <= 12; p++)
      if (mask[p-1]) s = s ^ 4'(p);
    e.syn = s;
    if (n == 0) begin
      e.data = d; e.flags = 3'b100; tag = "R6 clean";
    end else if (n == 1) begin
      e.data = d; e.flags = 3'b010;
      tag = mask[12] ? "R8 parity-bit error" : "R7 single error";
    end else if (n == 2) begin
      e.data = model_data(rx); e.flags = 3'b001; tag = "R9 double error";
    end else begin
      e.data = model_data(rx); e.flags = 3'b001; tag = "R10 syndrome beyond 12";
    end
    @(negedge clk);
    dec_valid_i = 1'b1;
    dec_word_i  = rx;
    dec_q.push_back(e);
    dec_tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    enc_valid_i = 1'b0;
    dec_valid_i = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && enc_valid_o) begin
      if (enc_q.size() == 0) check(1'b0, "R3 encoder output with nothing expected");
      else begin
        logic [12:0] x;
        string t;
        x = enc_q.pop_front();
        t = enc_tag_q.pop_front();
        check(enc_word_o == x, $sformatf("%s: word=%h expected %h", t, enc_word_o, x));
      end
    end
    if (!rst && dec_valid_o) begin
      if (dec_q.size() == 0) check(1'b0, "R3 decoder output with nothing expected");
      else begin
        dec_exp_t x;
        string t;
        x = dec_q.pop_front();
        t = dec_tag_q.pop_front();
        check(dec_syndrome_o == x.syn,
              $sformatf("R5 (%s): syndrome=%h expected %h", t, dec_syndrome_o, x.syn));
        check(dec_data_o == x.data && {dec_clean_o, dec_fixed_o, dec_fatal_o} == x.flags,
              $sformatf("%s: data=%h flags=%b expected data=%h flags=%b", t, dec_data_o,
                        {dec_clean_o, dec_fixed_o, dec_fatal_o}, x.data, x.flags));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] bytes [5];
    bytes = '{8'hC4, 8'h00, 8'hFF, 8'h5A, 8'hA5};
    repeat (3) @(negedge clk);
    // R4 reset state
    check(!enc_valid_o && !dec_valid_o && !dec_clean_o && !dec_fixed_o && !dec_fatal_o,
          $sformatf("R4 reset state: valids=%b%b flags=%b expected 00 000", enc_valid_o,
                    dec_valid_o, {dec_clean_o, dec_fixed_o, dec_fatal_o}));
    rst = 1'b0;

    // R1 worked example
    drive_enc(8'hC4, 13'h129C, "R1 example 0xC4");
    // R1 R2 every byte
    for (int i = 0; i < 256; i++) drive_enc(8'(i), model_enc(8'(i)), "R1/R2 encode");
    idle();
    @(negedge clk);
    // R3 idle valids
    check(!enc_valid_o && !dec_valid_o,
          $sformatf("R3 idle: valids=%b%b expected 00", enc_valid_o, dec_valid_o));

    foreach (bytes[b]) begin
      drive_dec(bytes[b], 13'h0000);
      for (int p = 0; p < 13; p++) drive_dec(bytes[b], 13'(1) << p);
      for (int a = 0; a < 13; a++)
        for (int c = a + 1; c < 13; c++)
          drive_dec(bytes[b], (13'(1) << a) | (13'(1) << c));
      // R10 syndromes 13, 14, 15 with odd parity
      drive_dec(bytes[b], 13'b0_0000_1000_1001);
      drive_dec(bytes[b], 13'b0_0000_1000_1010);
      drive_dec(bytes[b], 13'b0_0000_1000_1100);
    end
    idle();
    @(negedge clk);
    // R11 flags zero while idle
    check(!dec_valid_o && !dec_clean_o && !dec_fixed_o && !dec_fatal_o,
          $sformatf("R11 idle flags=%b expected 000", {dec_clean_o, dec_fixed_o, dec_fatal_o}));

    // R4 reset during traffic
    @(negedge clk);
    enc_valid_i = 1'b1;
    dec_valid_i = 1'b1;
    dec_word_i  = 13'h0001;
    rst = 1'b1;
    @(negedge clk);
    check(!enc_valid_o && !dec_valid_o && !dec_clean_o && !dec_fixed_o && !dec_fatal_o,
          $sformatf("R4 reset with valid inputs: valids=%b%b flags=%b expected 00 000",
                    enc_valid_o, dec_valid_o, {dec_clean_o, dec_fixed_o, dec_fatal_o}));
    enc_valid_i = 1'b0;
    dec_valid_i = 1'b0;
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(enc_q.size() == 0 && dec_q.size() == 0,
          $sformatf("R3 outstanding items: enc=%0d dec=%0d expected 0 0",
                    enc_q.size(), dec_q.size()));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule